// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Result Pair

This block executes 32-bit signed and unsigned multiplies and divides for a processor core that keeps 64-bit general registers. Results land in a pair of 64-bit result registers, HI and LO. A multiply puts the low word of the product in LO and the high word in HI. A divide puts the quotient in LO and the remainder in HI. Every 32-bit result is sign-extended to 64 bits, including unsigned results. The unit also executes moves between a general register and HI or LO. A multiply or a move-from also produces a writeback to the general register file.

Requests arrive on a valid/ready handshake. A request transfers on a rising edge when `req_valid` and `req_ready` are both high. `req_ready` is low for the whole time a divide is iterating. A requester that sees `req_ready` low must hold its request, or withdraw it; a request that is withdrawn before `req_ready` returns high has no effect. The writeback output is a plain one-cycle pulse with no back-pressure: the register file must take it in the cycle it appears. Division uses a restoring shift-subtract loop, one quotient bit per clock. Multiply and move operations complete on the edge that accepts them. No operand value raises an exception. Divide-by-zero and the most-negative-over-minus-one case both produce defined values.

Top module: `muldiv_unit`

## Requirements
- R1: While reset is held and after reset releases, HI and LO read zero, `busy`, `done` and `wb_valid` are low, and `req_ready` is high.
- R2: `req_ready` is low in every cycle that `busy` is high. A request offered only during those cycles is not taken, and it leaves HI and LO unchanged.
- R3: Op code 0 (signed multiply) and op code 1 (unsigned multiply) form the 64-bit product. They write sign-extended product bits 31:0 to LO and sign-extended bits 63:32 to HI on the accepting edge, and `done` pulses in the following cycle.
- R4: A multiply with a nonzero `req_dst` pulses `wb_valid` together with `done`, with `wb_idx` equal to `req_dst` and `wb_data` equal to the new LO. With `req_dst` equal to 0 there is no writeback pulse, but LO and HI are still updated.
- R5: After a divide is accepted, `busy` is high for exactly 32 cycles. HI and LO take the result on the edge that ends the last busy cycle, and `done` is high in the cycle after that edge.
- R6: Op code 2 (signed divide) truncates the quotient toward zero and gives the remainder the sign of the dividend, for every sign combination.
- R7: Op code 3 (unsigned divide) treats both operands as unsigned and sign-extends the 32-bit quotient and remainder from bit 31 into HI and LO.
- R8: A signed divide by zero sets LO to 1 when the dividend is negative and to all ones otherwise, and sets HI to the sign-extended dividend.
- R9: An unsigned divide by zero sets LO to all ones and HI to the sign-extended dividend.
- R10: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0xFFFFFFFF80000000 and HI = 0.
- R11: Op code 4 copies all 64 bits of `req_wide` into HI, and op code 5 copies them into LO. Each completes with a one-cycle `done` pulse.
- R12: Op code 6 (read HI) and op code 7 (read LO) pulse `wb_valid` with the full 64-bit register value on `wb_data` when `req_dst` is nonzero. They produce no writeback pulse when `req_dst` is 0.
- R13: HI and LO do not change in any cycle while a divide is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 3 | Operation code (see requirements) |
| req_a | input | 32 | First operand (multiplicand or dividend) |
| req_b | input | 32 | Second operand (multiplier or divisor) |
| req_wide | input | 64 | Source value for moves into HI or LO |
| req_dst | input | 5 | Destination register index for writebacks |
| busy | output | 1 | A divide is iterating |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 64 | HI result register |
| lo | output | 64 | LO result register |
| wb_valid | output | 1 | One-cycle writeback pulse |
| wb_idx | output | 5 | Writeback destination index |
| wb_data | output | 64 | Writeback value |

## Verification
The assertions check these properties on every cycle:
- A busy period lasts exactly 32 cycles and never longer.
- HI and LO hold still while a divide is in flight.
- Any writeback targets a nonzero index, coincides with `done`, and follows a multiply or a move-from.
- Every multiply or divide completion leaves both result registers sign-extended.

Only the directed scenarios can show that the values are right. These cover signed truncation for each sign combination, the divide-by-zero and most-negative cases, full 64-bit move behaviour, and a request withdrawn while the unit is busy.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  // Operation codes; the numeric values are part of the block's interface.
  typedef enum logic [2:0] {
    MD_MUL_S   = 3'd0,
    MD_MUL_U   = 3'd1,
    MD_DIV_S   = 3'd2,
    MD_DIV_U   = 3'd3,
    MD_TO_HI   = 3'd4,
    MD_TO_LO   = 3'd5,
    MD_FROM_HI = 3'd6,
    MD_FROM_LO = 3'd7
  } md_op_e;

endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  input  logic              is_signed,
  output logic [2*XLEN-1:0] prod
);
  localparam int PLEN = 2 * XLEN;

  logic [PLEN-1:0] ext_a;
  logic [PLEN-1:0] ext_b;

  // Widen both operands to the product width. A signed multiply extends
  // the sign bit, so the truncated product is correct for both kinds.
  always_comb begin
    ext_a = {{XLEN{is_signed & a[XLEN-1]}}, a};
    ext_b = {{XLEN{is_signed & b[XLEN-1]}}, b};
    prod  = ext_a * ext_b;
  end
endmodule

// File: rtl/muldiv_divcore.sv
module muldiv_divcore #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] num,
  input  logic [XLEN-1:0] den,
  output logic            active,
  output logic            last,
  output logic [XLEN-1:0] q_next,
  output logic [XLEN-1:0] r_next
);
  localparam int CW = $clog2(XLEN);

  logic [CW-1:0]   step_q;
  logic [XLEN-1:0] rem_q;
  logic [XLEN-1:0] quo_q;
  logic [XLEN-1:0] den_q;
  logic [XLEN:0]   shifted;
  logic [XLEN:0]   trial;
  logic            take;

  // One restoring step: shift the next dividend bit into the partial
  // remainder, then subtract the divisor if the difference stays positive.
  always_comb begin
    shifted = {rem_q, quo_q[XLEN-1]};
    trial   = shifted - {1'b0, den_q};
    take    = ~trial[XLEN];
    r_next  = take ? trial[XLEN-1:0] : shifted[XLEN-1:0];
    q_next  = {quo_q[XLEN-2:0], take};
    last    = active && (step_q == CW'(XLEN - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      step_q <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      step_q <= '0;
      rem_q  <= '0;
      quo_q  <= num;
      den_q  <= den;
    end else if (active) begin
      rem_q  <= r_next;
      quo_q  <= q_next;
      step_q <= step_q + CW'(1);
      if (last) active <= 1'b0;
    end
  end
endmodule

// File: rtl/muldiv_divfix.sv
module muldiv_divfix #(
  parameter int XLEN = 32
) (
  input  logic            is_signed,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] q_mag,
  input  logic [XLEN-1:0] r_mag,
  output logic [XLEN-1:0] q_out,
  output logic [XLEN-1:0] r_out
);
  localparam logic [XLEN-1:0] ALL_ONES = '1;
  localparam logic [XLEN-1:0] ONE      = XLEN'(1);
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

  logic a_neg;
  logic b_neg;

  // Turn the magnitude results into the defined final values, including
  // the two cases that give a fixed result instead of an exception.
  always_comb begin
    a_neg = is_signed & a[XLEN-1];
    b_neg = is_signed & b[XLEN-1];
    if (b == '0) begin
      q_out = a_neg ? ONE : ALL_ONES;
      r_out = a;
    end else if (is_signed && a == MOST_NEG && b == ALL_ONES) begin
      q_out = MOST_NEG;
      r_out = '0;
    end else begin
      q_out = (a_neg ^ b_neg) ? (~q_mag + ONE) : q_mag;
      r_out = a_neg ? (~r_mag + ONE) : r_mag;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [XLEN-1:0]   req_a,
  input  logic [XLEN-1:0]   req_b,
  input  logic [2*XLEN-1:0] req_wide,
  input  logic [RIDX-1:0]   req_dst,
  output logic              busy,
  output logic              done,
  output logic [2*XLEN-1:0] hi,
  output logic [2*XLEN-1:0] lo,
  output logic              wb_valid,
  output logic [RIDX-1:0]   wb_idx,
  output logic [2*XLEN-1:0] wb_data
);
  localparam int WLEN = 2 * XLEN;

  function automatic logic [WLEN-1:0] sext(input logic [XLEN-1:0] v);
    return {{XLEN{v[XLEN-1]}}, v};
  endfunction

  md_op_e          op;
  logic            accept;
  logic            op_signed;
  logic            div_start;
  logic [XLEN-1:0] mag_a;
  logic [XLEN-1:0] mag_b;
  logic [WLEN-1:0] prod;
  logic            div_act;
  logic            div_last;
  logic [XLEN-1:0] q_step;
  logic [XLEN-1:0] r_step;
  logic [XLEN-1:0] q_fin;
  logic [XLEN-1:0] r_fin;
  logic            d_signed_q;
  logic [XLEN-1:0] d_a_q;
  logic [XLEN-1:0] d_b_q;

  always_comb begin
    op        = md_op_e'(req_op);
    req_ready = ~div_act;
    busy      = div_act;
    accept    = req_valid & req_ready;
    op_signed = (op == MD_MUL_S) || (op == MD_DIV_S);
    div_start = accept && ((op == MD_DIV_S) || (op == MD_DIV_U));
    mag_a     = (op_signed && req_a[XLEN-1]) ? (~req_a + XLEN'(1)) : req_a;
    mag_b     = (op_signed && req_b[XLEN-1]) ? (~req_b + XLEN'(1)) : req_b;
  end

  muldiv_mul #(.XLEN(XLEN)) mul_i (
    .a         (req_a),
    .b         (req_b),
    .is_signed (op_signed),
    .prod      (prod)
  );

  muldiv_divcore #(.XLEN(XLEN)) div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (div_start),
    .num    (mag_a),
    .den    (mag_b),
    .active (div_act),
    .last   (div_last),
    .q_next (q_step),
    .r_next (r_step)
  );

  muldiv_divfix #(.XLEN(XLEN)) fix_i (
    .is_signed (d_signed_q),
    .a         (d_a_q),
    .b         (d_b_q),
    .q_mag     (q_step),
    .r_mag     (r_step),
    .q_out     (q_fin),
    .r_out     (r_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi         <= '0;
      lo         <= '0;
      done       <= 1'b0;
      wb_valid   <= 1'b0;
      wb_idx     <= '0;
      wb_data    <= '0;
      d_signed_q <= 1'b0;
      d_a_q      <= '0;
      d_b_q      <= '0;
    end else begin
      done     <= 1'b0;
      wb_valid <= 1'b0;
      if (accept) begin
        unique case (op)
          MD_MUL_S, MD_MUL_U: begin
            lo   <= sext(prod[XLEN-1:0]);
            hi   <= sext(prod[WLEN-1:XLEN]);
            done <= 1'b1;
            if (req_dst != '0) begin
              wb_valid <= 1'b1;
              wb_idx   <= req_dst;
              wb_data  <= sext(prod[XLEN-1:0]);
            end
          end
          MD_DIV_S, MD_DIV_U: begin
            d_signed_q <= op_signed;
            d_a_q      <= req_a;
            d_b_q      <= req_b;
          end
          MD_TO_HI: begin
            hi   <= req_wide;
            done <= 1'b1;
          end
          MD_TO_LO: begin
            lo   <= req_wide;
            done <= 1'b1;
          end
          MD_FROM_HI, MD_FROM_LO: begin
            done <= 1'b1;
            if (req_dst != '0) begin
              wb_valid <= 1'b1;
              wb_idx   <= req_dst;
              wb_data  <= (op == MD_FROM_HI) ? hi : lo;
            end
          end
          default: ;
        endcase
      end
      if (div_last) begin
        lo   <= sext(q_fin);
        hi   <= sext(r_fin);
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic              busy,
  input logic              done,
  input logic [2*XLEN-1:0] hi,
  input logic [2*XLEN-1:0] lo,
  input logic              wb_valid,
  input logic [RIDX-1:0]   wb_idx
);
  localparam int BW = $clog2(XLEN) + 1;

  logic [BW-1:0] busy_run;
  logic [2:0]    last_op;
  logic          arith_op;
  logic          wb_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_run <= '0;
      last_op  <= '0;
    end else begin
      busy_run <= busy ? busy_run + BW'(1) : '0;
      if (req_valid && req_ready) last_op <= req_op;
    end
  end

  always_comb begin
    arith_op = (last_op <= 3'd3);
    wb_op    = (last_op <= 3'd1) || (last_op >= 3'd6);
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == BW'(XLEN)));

  // R5
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < BW'(XLEN)));

  // R13
  hilo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(hi) && $stable(lo)));

  // R4
  wb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_idx != '0 && done));

  // R12
  wb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_op);

  // R3
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && arith_op) |->
      (hi[2*XLEN-1:XLEN] == {XLEN{hi[XLEN-1]}} &&
       lo[2*XLEN-1:XLEN] == {XLEN{lo[XLEN-1]}}));
endmodule

bind muldiv_unit muldiv_unit_chk #(.XLEN(XLEN), .RIDX(RIDX)) chk_i (.*);

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [31:0] req_a = '0;
  logic [31:0] req_b = '0;
  logic [63:0] req_wide = '0;
  logic [4:0]  req_dst = '0;
  logic        busy;
  logic        done;
  logic [63:0] hi;
  logic [63:0] lo;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  muldiv_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .req_wide(req_wide),
    .req_dst(req_dst), .busy(busy), .done(done), .hi(hi), .lo(lo),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drives one request at a negedge and waits for done; returns cycle count
  // from acceptance to done, busy cycles seen, and the writeback at done.
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] w, input logic [4:0] d,
                        output int n, output int nb, output logic wv,
                        output logic [4:0] wi, output logic [63:0] wd);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b; req_wide = w; req_dst = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; nb = 0;
    while (!done && n < 100) begin
      if (busy) nb++;
      @(negedge clk);
      n++;
    end
    wv = wb_valid; wi = wb_idx; wd = wb_data;
  endtask

  task automatic t_reset();
    chk("R1 hi", hi, 64'h0);
    chk("R1 lo", lo, 64'h0);
    chk("R1 busy/done/wb", {61'h0, busy, done, wb_valid}, 64'h0);
    chk("R1 ready", {63'h0, req_ready}, 64'h1);
  endtask

  task automatic t_mul(input bit sgn, input logic [31:0] a, input logic [31:0] b, input logic [4:0] d);
    int n, nb; logic wv; logic [4:0] wi; logic [63:0] wd;
    logic [63:0] p;
    p = sgn ? 64'($signed(sx(a)) * $signed(sx(b))) : ({32'h0, a} * {32'h0, b});
    run_op(sgn ? 3'd0 : 3'd1, a, b, 64'h0, d, n, nb, wv, wi, wd);
    chk("R3 mul latency", 64'(n), 64'd1);
    chk("R3 mul lo", lo, sx(p[31:0]));
    chk("R3 mul hi", hi, sx(p[63:32]));
    if (d != 0) begin
      chk("R4 wb valid", {63'h0, wv}, 64'h1);
      chk("R4 wb idx", {59'h0, wi}, {59'h0, d});
      chk("R4 wb data", wd, sx(p[31:0]));
    end else begin
      chk("R4 no wb for index 0", {63'h0, wv}, 64'h0);
    end
  endtask

  task automatic t_div(input bit sgn, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] eq, input logic [31:0] er, input string tag);
    int n, nb; logic wv; logic [4:0] wi; logic [63:0] wd;
    run_op(sgn ? 3'd2 : 3'd3, a, b, 64'h0, 5'd3, n, nb, wv, wi, wd);
    chk({"R5 div latency ", tag}, 64'(n), 64'd33);
    chk({"R5 busy cycles ", tag}, 64'(nb), 64'd32);
    chk({tag, " lo"}, lo, sx(eq));
    chk({tag, " hi"}, hi, sx(er));
    chk("R4 no wb on divide", {63'h0, wv}, 64'h0);
  endtask

  task automatic t_div_signed();
    logic signed [31:0] as_[4] = '{32'sd7, -32'sd7, -32'sd7, 32'sd100};
    logic signed [31:0] bs_[4] = '{-32'sd2, 32'sd2, -32'sd2, 32'sd7};
    for (int i = 0; i < 4; i++)
      t_div(1'b1, as_[i], bs_[i], as_[i] / bs_[i], as_[i] % bs_[i], "R6 signed");
  endtask

  task automatic t_div_unsigned();
    logic [31:0] as_[3] = '{32'hFFFFFFFF, 32'hFFFFFFF0, 32'h80000005};
    logic [31:0] bs_[3] = '{32'h1, 32'h3, 32'h10};
    for (int i = 0; i < 3; i++)
      t_div(1'b0, as_[i], bs_[i], as_[i] / bs_[i], as_[i] % bs_[i], "R7 unsigned");
  endtask

  task automatic t_div_special();
    t_div(1'b1, 32'hFFFFFFF9, 32'h0, 32'h1, 32'hFFFFFFF9, "R8 neg by zero");
    t_div(1'b1, 32'h00000009, 32'h0, 32'hFFFFFFFF, 32'h00000009, "R8 pos by zero");
    t_div(1'b0, 32'h80000001, 32'h0, 32'hFFFFFFFF, 32'h80000001, "R9 unsigned by zero");
    t_div(1'b1, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'h0, "R10 most negative");
  endtask

  task automatic t_busy_ignore();
    int guard;
    bit moved;
    logic [63:0] hi0, lo0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = 3'd2; req_a = 32'd50; req_b = 32'd6;
    @(negedge clk);
    req_op = 3'd5; req_wide = 64'hDEAD_BEEF_0000_1111;
    chk("R2 ready low while busy", {62'h0, busy, req_ready}, 64'h2);
    hi0 = hi; lo0 = lo;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0; moved = 0;
    while (!done && guard < 100) begin
      if (hi !== hi0 || lo !== lo0) moved = 1;
      @(negedge clk);
      guard++;
    end
    chk("R13 hi/lo unchanged during divide", {63'h0, moved}, 64'h0);
    chk("R2 withdrawn request ignored lo", lo, sx(32'd8));
    chk("R2 withdrawn request ignored hi", hi, sx(32'd2));
  endtask

  task automatic t_move();
    int n, nb; logic wv; logic [4:0] wi; logic [63:0] wd;
    run_op(3'd4, 32'h0, 32'h0, 64'h0123_4567_89AB_CDEF, 5'd0, n, nb, wv, wi, wd);
    chk("R11 to-HI done latency", 64'(n), 64'd1);
    chk("R11 to-HI value", hi, 64'h0123_4567_89AB_CDEF);
    run_op(3'd5, 32'h0, 32'h0, 64'h7FED_CBA9_0000_0001, 5'd0, n, nb, wv, wi, wd);
    chk("R11 to-LO value", lo, 64'h7FED_CBA9_0000_0001);
    chk("R11 to-LO leaves HI", hi, 64'h0123_4567_89AB_CDEF);
    run_op(3'd6, 32'h0, 32'h0, 64'h0, 5'd9, n, nb, wv, wi, wd);
    chk("R12 from-HI wb valid", {63'h0, wv}, 64'h1);
    chk("R12 from-HI wb idx", {59'h0, wi}, 64'd9);
    chk("R12 from-HI wb data", wd, 64'h0123_4567_89AB_CDEF);
    run_op(3'd7, 32'h0, 32'h0, 64'h0, 5'd31, n, nb, wv, wi, wd);
    chk("R12 from-LO wb data", wd, 64'h7FED_CBA9_0000_0001);
    run_op(3'd7, 32'h0, 32'h0, 64'h0, 5'd0, n, nb, wv, wi, wd);
    chk("R12 no wb for index 0", {63'h0, wv}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul(1'b1, 32'hFFFFFFFD, 32'd7, 5'd5);
    t_mul(1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd1);
    t_mul(1'b1, 32'h7FFFFFFF, 32'h80000000, 5'd0);
    t_mul(1'b0, 32'h00012345, 32'h00010000, 5'd17);
    t_div_signed();
    t_div_unsigned();
    t_div_special();
    t_busy_ignore();
    t_move();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule